// File: doc/BRIEF.md
# Tiled Depth Buffer Address Generator

This block turns a pixel coordinate and a surface pitch into the byte address of that pixel inside a depth surface. A depth surface can be stored in one of two ways. In the linear layout, the pixels follow one another row by row. In the tiled layout, the surface is cut into rectangular tiles. Inside each tile, coordinate bits and tile-index bits are interleaved, and two of the address bits are formed by XOR swizzling. Elements are either 16 or 32 bits wide. The 32-bit tiled layout comes in two tile geometries: an 8x8-pixel tile and a 16x16-pixel tile.

A requester presents the coordinate, the pitch and the mode bits together with a valid strobe. One clock later the block returns the byte address with a valid strobe. It also returns a flag that marks a tiled request whose pitch is not a whole number of tiles wide. Adding a window origin, and any access to memory, are the caller's job. The address is relative to the base of the surface.

Top module: `tdab_addr_gen`

## Requirements
- R1: With `req_tiled`=0 and `req_wide`=1, the address is 4*(x + y*pitch), truncated to 32 bits.
- R2: With `req_tiled`=0 and `req_wide`=0, the address is 2*(x + y*pitch). In linear mode `req_fine` has no effect.
- R3: Bit layout for 32-bit tiled elements:
  - bits[1:0] are 0 and bits[4:2] are x[2:0];
  - bits[6:5] are y[1:0] and bit 7 is x[4]^y[2];
  - bits[9:8] are tile index bits[1:0] and bit 10 is y[3];
  - bit 11 is x[3]^y[4], and bits[31:12] are tile index bits from bit 2 upward.
- R4: For 32-bit tiled elements with `req_fine`=1, the tile index is floor(y/8)*floor(pitch/8) + floor(x/8).
- R5: For 32-bit tiled elements with `req_fine`=0, the tile index is floor(y/16)*floor(pitch/16) + floor(x/16).
- R6: Bit layout and tile index for 16-bit tiled elements. `req_fine` has no effect in this mode.
  - bit 0 is 0, bits[3:1] are x[2:0] and bits[6:4] are y[2:0];
  - bit 7 is x[3], bits[9:8] are tile index bits[1:0] and bit 10 is y[3];
  - bit 11 is x[4]^y[4], and bits[31:12] are tile index bits from bit 2 upward;
  - the tile index is floor(y/16)*floor(pitch/32) + floor(x/32).
- R7: `resp_misalign` is 1 for a tiled request whose pitch is not a multiple of the tile width. The tile width is 8 (32-bit, fine), 16 (32-bit, coarse) or 32 (16-bit). The flag is 0 for every linear request.
- R8: `resp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R9: When no request is accepted, `resp_addr` and `resp_misalign` keep their previous values.
- R10: While reset is asserted, `resp_valid`, `resp_addr` and `resp_misalign` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to `clk` |
| req_valid | input | 1 | Request strobe |
| req_x | input | CRD_W | Pixel column |
| req_y | input | CRD_W | Pixel row |
| req_pitch | input | PITCH_W | Surface pitch in pixels |
| req_wide | input | 1 | 1: 32-bit elements, 0: 16-bit elements |
| req_tiled | input | 1 | 1: tiled layout, 0: linear layout |
| req_fine | input | 1 | 32-bit tiled only. 1: 8x8 tiles, 0: 16x16 tiles |
| resp_valid | output | 1 | Result strobe, one cycle after the request |
| resp_addr | output | ADDR_W | Byte address |
| resp_misalign | output | 1 | Tiled pitch not a whole number of tiles |

## Verification
The only state in the block is the single output register and its valid flag. A wrong value in either shows up at the ports on the very next cycle.

A wrong tile index or a wrong geometry decode does not fail in every case. It corrupts only bits 8 and above, and only for coordinates that cross a tile boundary. For this reason the stimulus spreads coordinates over the whole range and varies the pitch. A swapped or missing XOR shows up in bits 7 and 11 as soon as the coordinate bits that feed them differ. A stuck load enable breaks the hold and update behaviour in the first cycle after a request.

// File: rtl/tdab_pkg.sv
`timescale 1ns/1ps
package tdab_pkg;
  // Addressing geometry picked from the mode inputs
  typedef enum logic [1:0] {
    GEO_LINEAR  = 2'd0,
    GEO_W32_T8  = 2'd1,
    GEO_W32_T16 = 2'd2,
    GEO_W16     = 2'd3
  } geo_e;

  // Shift amounts that turn pixel units into tile units
  typedef struct packed {
    logic [2:0] x_sh;
    logic [2:0] y_sh;
    logic [2:0] p_sh;
  } tile_shift_t;
endpackage

// File: rtl/tdab_geo_decode.sv
`timescale 1ns/1ps
module tdab_geo_decode
  import tdab_pkg::*;
#(
  parameter int PITCH_W = 14
) (
  input  logic               tiled,
  input  logic               wide,
  input  logic               fine,
  input  logic [PITCH_W-1:0] pitch,
  output geo_e               geo,
  output tile_shift_t        shift,
  output logic               misalign
);
  logic [PITCH_W-1:0] align_mask;

  always_comb begin
    if (!tiled)     geo = GEO_LINEAR;
    else if (!wide) geo = GEO_W16;
    else if (fine)  geo = GEO_W32_T8;
    else            geo = GEO_W32_T16;
  end

  always_comb begin
    unique case (geo)
      GEO_W32_T8:  shift = '{x_sh: 3'd3, y_sh: 3'd3, p_sh: 3'd3};
      GEO_W32_T16: shift = '{x_sh: 3'd4, y_sh: 3'd4, p_sh: 3'd4};
      GEO_W16:     shift = '{x_sh: 3'd5, y_sh: 3'd4, p_sh: 3'd5};
      default:     shift = '{x_sh: 3'd0, y_sh: 3'd0, p_sh: 3'd0};
    endcase
  end

  // Tile width is 1 << p_sh; pitch must be a multiple of it
  always_comb begin
    align_mask = (PITCH_W'(1) << shift.p_sh) - PITCH_W'(1);
    misalign   = (geo != GEO_LINEAR) && ((pitch & align_mask) != '0);
  end
endmodule

// File: rtl/tdab_tile_index.sv
`timescale 1ns/1ps
module tdab_tile_index
  import tdab_pkg::*;
#(
  parameter int CRD_W   = 14,
  parameter int PITCH_W = 14,
  parameter int IDX_W   = CRD_W + PITCH_W + 1
) (
  input  logic [CRD_W-1:0]   x,
  input  logic [CRD_W-1:0]   y,
  input  logic [PITCH_W-1:0] pitch,
  input  tile_shift_t        shift,
  output logic [IDX_W-1:0]   idx
);
  logic [CRD_W-1:0]   tx;
  logic [CRD_W-1:0]   ty;
  logic [PITCH_W-1:0] tp;

  always_comb begin
    tx  = x >> shift.x_sh;
    ty  = y >> shift.y_sh;
    tp  = pitch >> shift.p_sh;
    idx = IDX_W'(ty) * IDX_W'(tp) + IDX_W'(tx);
  end
endmodule

// File: rtl/tdab_swizzle.sv
`timescale 1ns/1ps
module tdab_swizzle #(
  parameter int IDX_W  = 29,
  parameter int ADDR_W = 32
) (
  input  logic              wide,
  input  logic [4:0]        xl,
  input  logic [4:0]        yl,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - 12;
  logic [IDX_W-1:0] idx_hi;
  logic [11:0]      low;

  always_comb begin
    idx_hi = idx >> 2;
    if (wide) begin
      low = {xl[3] ^ yl[4], yl[3], idx[1:0], xl[4] ^ yl[2], yl[1:0], xl[2:0], 2'b00};
    end else begin
      low = {xl[4] ^ yl[4], yl[3], idx[1:0], xl[3], yl[2:0], xl[2:0], 1'b0};
    end
    addr = {HI_W'(idx_hi), low};
  end
endmodule

// File: rtl/tdab_linear.sv
`timescale 1ns/1ps
module tdab_linear #(
  parameter int CRD_W   = 14,
  parameter int PITCH_W = 14,
  parameter int ADDR_W  = 32
) (
  input  logic               wide,
  input  logic [CRD_W-1:0]   x,
  input  logic [CRD_W-1:0]   y,
  input  logic [PITCH_W-1:0] pitch,
  output logic [ADDR_W-1:0]  addr
);
  localparam int EL_W = CRD_W + PITCH_W + 1;
  logic [EL_W-1:0] elem;

  always_comb begin
    elem = EL_W'(y) * EL_W'(pitch) + EL_W'(x);
    addr = ADDR_W'(elem) << (wide ? 2 : 1);
  end
endmodule

// File: rtl/tdab_addr_gen.sv
`timescale 1ns/1ps
module tdab_addr_gen
  import tdab_pkg::*;
#(
  parameter int CRD_W   = 14,
  parameter int PITCH_W = 14,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CRD_W-1:0]   req_x,
  input  logic [CRD_W-1:0]   req_y,
  input  logic [PITCH_W-1:0] req_pitch,
  input  logic               req_wide,
  input  logic               req_tiled,
  input  logic               req_fine,
  output logic               resp_valid,
  output logic [ADDR_W-1:0]  resp_addr,
  output logic               resp_misalign
);
  localparam int IDX_W = CRD_W + PITCH_W + 1;

  geo_e              geo;
  tile_shift_t       shift;
  logic              mis_c;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] tiled_addr;
  logic [ADDR_W-1:0] lin_addr;
  logic [ADDR_W-1:0] addr_nxt;
  logic              mis_nxt;
  logic              load_en;

  tdab_geo_decode #(.PITCH_W(PITCH_W)) u_geo (
    .tiled(req_tiled), .wide(req_wide), .fine(req_fine), .pitch(req_pitch),
    .geo(geo), .shift(shift), .misalign(mis_c)
  );

  tdab_tile_index #(.CRD_W(CRD_W), .PITCH_W(PITCH_W), .IDX_W(IDX_W)) u_idx (
    .x(req_x), .y(req_y), .pitch(req_pitch), .shift(shift), .idx(idx)
  );

  tdab_swizzle #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_swz (
    .wide(req_wide), .xl(req_x[4:0]), .yl(req_y[4:0]), .idx(idx), .addr(tiled_addr)
  );

  tdab_linear #(.CRD_W(CRD_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_lin (
    .wide(req_wide), .x(req_x), .y(req_y), .pitch(req_pitch), .addr(lin_addr)
  );

  // Next-state selection
  always_comb begin
    load_en  = req_valid;
    addr_nxt = (geo == GEO_LINEAR) ? lin_addr : tiled_addr;
    mis_nxt  = mis_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_valid <= 1'b0;
    else        resp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_addr     <= '0;
      resp_misalign <= 1'b0;
    end else if (load_en) begin
      resp_addr     <= addr_nxt;
      resp_misalign <= mis_nxt;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(resp_addr) && $stable(resp_misalign)));
  // R7
  lin_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_tiled) |=> !resp_misalign);
  // R1
  lin32_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_tiled && req_wide) |=> (resp_addr[1:0] == 2'b00));
  // R2
  lin16_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_tiled && !req_wide) |=> (resp_addr[0] == 1'b0));
  // R3
  t32_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_tiled && req_wide) |=>
      (resp_addr[4:0] == {$past(req_x[2:0]), 2'b00}));
  // R6
  t16_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_tiled && !req_wide) |=>
      (resp_addr[3:0] == {$past(req_x[2:0]), 1'b0}));
endmodule

// File: tb/test_tdab_addr_gen.sv
`timescale 1ns/1ps
module test_tdab_addr_gen;
  localparam int CW = 14;
  localparam int PW = 14;
  localparam int AW = 32;
  localparam real CLK_P = 8.0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [CW-1:0] req_x, req_y;
  logic [PW-1:0] req_pitch;
  logic          req_wide, req_tiled, req_fine;
  logic          resp_valid;
  logic [AW-1:0] resp_addr;
  logic          resp_misalign;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state: what the outputs must show after the next edge
  bit          exp_valid = 0;
  logic [31:0] exp_addr = '0;
  bit          exp_mis = 0;
  string       exp_tag = "R10";

  always #(CLK_P/2) clk = ~clk;

  tdab_addr_gen #(.CRD_W(CW), .PITCH_W(PW), .ADDR_W(AW)) i_tdab_addr_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
    .req_pitch(req_pitch), .req_wide(req_wide), .req_tiled(req_tiled),
    .req_fine(req_fine), .resp_valid(resp_valid), .resp_addr(resp_addr),
    .resp_misalign(resp_misalign)
  );

  function automatic longint bitof(longint v, int k);
    return (v / (longint'(1) << k)) % 2;
  endfunction

  function automatic longint ref_addr(longint x, longint y, longint p, bit w, bit t, bit f);
    longint ba, a, tw, th;
    if (!t) return ((w ? 4 : 2) * (x + y * p)) % (longint'(1) << 32);
    if (w) begin
      tw = f ? 8 : 16; th = tw;
      ba = (y / th) * (p / tw) + (x / tw);
      a = (x % 8) * 4 + (y % 4) * 32 + ((bitof(x,4) + bitof(y,2)) % 2) * 128
        + (ba % 4) * 256 + bitof(y,3) * 1024 + ((bitof(x,3) + bitof(y,4)) % 2) * 2048;
    end else begin
      ba = (y / 16) * (p / 32) + (x / 32);
      a = (x % 8) * 2 + (y % 8) * 16 + bitof(x,3) * 128 + (ba % 4) * 256
        + bitof(y,3) * 1024 + ((bitof(x,4) + bitof(y,4)) % 2) * 2048;
    end
    a = a + (ba / 4) * 4096;
    return a % (longint'(1) << 32);
  endfunction

  function automatic bit ref_mis(longint p, bit w, bit t, bit f);
    longint tw;
    if (!t) return 0;
    tw = w ? (f ? 8 : 16) : 32;
    return (p % tw) != 0;
  endfunction

  task automatic compare();
    checks++;
    if (resp_valid !== exp_valid) begin
      errors++;
      $display("FAIL R8 resp_valid actual=%0b expected=%0b at %0t", resp_valid, exp_valid, $time);
    end
    checks++;
    if (resp_addr !== exp_addr) begin
      errors++;
      $display("FAIL %s resp_addr actual=%08h expected=%08h at %0t", exp_tag, resp_addr, exp_addr, $time);
    end
    checks++;
    if (resp_misalign !== exp_mis) begin
      errors++;
      $display("FAIL %s/R7 resp_misalign actual=%0b expected=%0b at %0t", exp_tag, resp_misalign, exp_mis, $time);
    end
  endtask

  // One cycle: check what the previous edge produced, then drive the next input
  task automatic step(bit v, int x, int y, int p, bit w, bit t, bit f, string tag);
    @(negedge clk);
    compare();
    req_valid = v; req_x = CW'(x); req_y = CW'(y); req_pitch = PW'(p);
    req_wide = w; req_tiled = t; req_fine = f;
    exp_valid = v;
    if (v) begin
      exp_addr = 32'(ref_addr(x, y, p, w, t, f));
      exp_mis  = ref_mis(p, w, t, f);
      exp_tag  = tag;
    end else begin
      exp_tag = "R9";
    end
  endtask

  function automatic string mode_tag(bit w, bit t, bit f);
    if (!t) return w ? "R1" : "R2";
    if (!w) return "R6";
    return f ? "R4" : "R5";
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_x = '0; req_y = '0; req_pitch = '0;
    req_wide = 0; req_tiled = 0; req_fine = 0;
    repeat (3) @(negedge clk);
    compare(); // R10 reset state
    rst_n = 1'b1;

    // R1 / R2 linear
    step(1, 0, 0, 64, 1, 0, 0, "R1");
    step(1, 5, 3, 100, 1, 0, 1, "R1");
    step(1, 16383, 16383, 16383, 1, 0, 0, "R1");
    step(1, 7, 9, 33, 0, 0, 0, "R2");
    step(1, 7, 9, 33, 0, 0, 1, "R2"); // variant ignored in linear mode
    // R3/R4 32-bit fine tiles
    step(1, 31, 31, 256, 1, 1, 1, "R3");
    step(1, 0, 0, 256, 1, 1, 1, "R4");
    step(1, 1000, 777, 2048, 1, 1, 1, "R4");
    // R5 32-bit coarse tiles
    step(1, 1000, 777, 2048, 1, 1, 0, "R5");
    step(1, 16383, 16383, 16368, 1, 1, 0, "R5");
    // R6 16-bit tiles, variant has no effect
    step(1, 300, 211, 512, 0, 1, 0, "R6");
    step(1, 300, 211, 512, 0, 1, 1, "R6");
    // R7 misaligned pitch in each geometry, and linear never flags
    step(1, 4, 4, 12, 1, 1, 1, "R7");
    step(1, 4, 4, 24, 1, 1, 0, "R7");
    step(1, 4, 4, 48, 0, 1, 0, "R7");
    step(1, 4, 4, 13, 1, 0, 0, "R7");
    // R9 hold over idle cycles, R8 valid drops
    step(1, 123, 45, 640, 1, 1, 0, "R5");
    step(0, 1, 2, 3, 0, 0, 0, "R9");
    step(0, 9999, 8888, 77, 1, 1, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R9");

    // Random traffic across all modes with occasional gaps
    for (int i = 0; i < 3000; i++) begin
      bit v, w, t, f;
      int x, y, p;
      v = ($urandom % 5) != 0;
      w = $urandom; t = $urandom; f = $urandom;
      x = $urandom % (1 << CW);
      y = $urandom % (1 << CW);
      p = (($urandom % 4) == 0) ? ($urandom % (1 << PW)) : (($urandom % 512) * 32);
      step(v, x, y, p, w, t, f, mode_tag(w, t, f));
    end
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    @(negedge clk);
    compare();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule